// File: doc/BRIEF.md
# Two-Bank Register-Mapped Interrupt Controller

This block gathers 22 interrupt sources and presents them to a processor through a small word-addressed register bus with 32-bit data. Every source passes through a two-flop synchroniser. Software then chooses, per source, whether the status bit follows the live synchronised level or catches a rising edge and holds it until an acknowledge clears it. The status is gated by a per-source enable mask, and the main request output rises whenever any enabled status bit is set.

The register map is held twice. The lower bank drives the main request output. The upper bank has its own enable, mode, spare and latch storage, and it drives only a secondary, fast-style request output. Both banks see the same synchronised sources. Reads are combinational from the word address. A write is taken on the clock edge at which the write enable is high.

Top module: `irq_ctrl`

## Requirements
- R1: Only bits 21:0 of each register hold data. Bits 31:22 of every read are zero, and the same bits of write data are discarded.
- R2: Word 0 (byte offset 0x00) is read-only raw status. A source whose mode bit is 0 shows its input level there two clock edges after the input changes.
- R3: A source whose mode bit is 1 sets its raw status bit on a rising edge of the synchronised input. The bit stays set after the input falls, until it is acknowledged.
- R4: Word 1 (offset 0x04) is the read/write enable mask. It resets to 0x00003011.
- R5: Word 2 (offset 0x08) is write-only acknowledge and reads as zero. Writing 1 to a bit clears that source's latched status. For a source in level mode the write has no effect.
- R6: If an acknowledge of a bit and a new rising edge of the same source fall in the same cycle, the bit stays set.
- R7: Word 3 (offset 0x0C) selects the mode per source, where 1 means edge-latched and 0 means level. It resets to 0x00000019. Clearing a mode bit makes that status bit follow the input level again.
- R8: Word 4 (offset 0x10) is a spare read/write register with no side effect. It resets to zero.
- R9: Word 5 (offset 0x14) reads raw status AND enable for its bank.
- R10: Words 6 and 7 (offsets 0x18 to 0x1F) read zero, and writes to them have no effect.
- R11: Words 8 to 15 (offsets 0x20 to 0x3F) form a second bank with the same layout and reset values but with separate storage. Only this bank drives `irq_sec_o`, and nothing in it affects `irq_o`.
- R12: `irq_o` is the OR of the main bank's masked status, registered. It changes one clock edge after the masked status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address: bit 3 selects the bank, bits 2:0 select the register |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 22 | Interrupt source levels, asynchronous |
| irq_o | output | 1 | Main interrupt request |
| irq_sec_o | output | 1 | Secondary interrupt request from the upper bank |

## Verification
The edge-capture and hold assertions check the main bank only in cycles with no bus write. A write to the mode or acknowledge word may legally change a latched bit, so those properties assume that such writes are the only thing that can clear a latch. The same-cycle race property assumes the acknowledge is presented as one single-cycle write. To stay within these assumptions, the stimulus changes sources only on falling edges and holds each write strobe for exactly one cycle. The race test times its acknowledge to the exact cycle in which the synchronised rising edge appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // register selector inside one bank (word address bits 2:0)
  localparam int unsigned REG_SEL_W = 3;
  localparam int unsigned WADDR_W   = REG_SEL_W + 1;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_RAW    = 3'd0,
    REG_EN     = 3'd1,
    REG_ACK    = 3'd2,
    REG_MODE   = 3'd3,
    REG_SPARE  = 3'd4,
    REG_MASKED = 3'd5,
    REG_HOLE6  = 3'd6,
    REG_HOLE7  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_pkg::*;
#(
  parameter int unsigned         NUM_SRC  = 22,
  parameter logic [NUM_SRC-1:0]  EN_RST   = NUM_SRC'(32'h0000_3011),
  parameter logic [NUM_SRC-1:0]  MODE_RST = NUM_SRC'(32'h0000_0019)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] src_rise,
  input  logic               wr_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] wr_val,
  output logic [NUM_SRC-1:0] rd_val,
  output logic [NUM_SRC-1:0] raw_stat,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] mode_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] latch_q;
  logic [NUM_SRC-1:0] spare_q;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] masked;

  // per-source status select: latched bit or live level
  function automatic logic [NUM_SRC-1:0] pick_status(
    input logic [NUM_SRC-1:0] mode, latched, level);
    return (mode & latched) | (~mode & level);
  endfunction

  // next latch value: ack clears, a rising edge wins over the ack
  function automatic logic [NUM_SRC-1:0] next_latch(
    input logic [NUM_SRC-1:0] mode, cur, ack, rise);
    return mode & ((cur & ~ack) | rise);
  endfunction

  function automatic logic any_pending(
    input logic [NUM_SRC-1:0] stat, en);
    return |(stat & en);
  endfunction

  assign ack_vec  = (wr_en && sel == REG_ACK) ? wr_val : '0;
  assign raw_stat = pick_status(mode_q, latch_q, src_lvl);
  assign masked   = raw_stat & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= EN_RST;
      mode_q  <= MODE_RST;
      spare_q <= '0;
      latch_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      latch_q <= next_latch(mode_q, latch_q, ack_vec, src_rise);
      irq_q   <= any_pending(raw_stat, en_q);
      if (wr_en) begin
        case (sel)
          REG_EN:    en_q    <= wr_val;
          REG_MODE:  mode_q  <= wr_val;
          REG_SPARE: spare_q <= wr_val;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      REG_RAW:    rd_val = raw_stat;
      REG_EN:     rd_val = en_q;
      REG_MODE:   rd_val = mode_q;
      REG_SPARE:  rd_val = spare_q;
      REG_MASKED: rd_val = masked;
      default:    rd_val = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned        NUM_SRC  = 22,
  parameter int unsigned        DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] EN_RST   = NUM_SRC'(32'h0000_3011),
  parameter logic [NUM_SRC-1:0] MODE_RST = NUM_SRC'(32'h0000_0019)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_o,
  output logic               irq_sec_o
);
  localparam int unsigned NUM_BANKS = 2;

  // named internal events, used by the bound checker
  logic [NUM_SRC-1:0]                sync_lvl;
  logic [NUM_SRC-1:0]                prev_lvl;
  logic [NUM_SRC-1:0]                rise_v;
  logic [NUM_BANKS-1:0][NUM_SRC-1:0] raw_b;
  logic [NUM_BANKS-1:0][NUM_SRC-1:0] en_b;
  logic [NUM_BANKS-1:0][NUM_SRC-1:0] mode_b;
  logic [NUM_BANKS-1:0][NUM_SRC-1:0] rd_b;
  logic [NUM_BANKS-1:0]              irq_b;

  logic     bank_sel;
  reg_sel_e reg_sel;
  logic     unused_wdata_hi;

  assign bank_sel        = bus_addr[WADDR_W-1];
  assign reg_sel         = reg_sel_e'(bus_addr[REG_SEL_W-1:0]);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (src_in),
    .q    (sync_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else        prev_lvl <= sync_lvl;
  end

  assign rise_v = sync_lvl & ~prev_lvl;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank #(
      .NUM_SRC (NUM_SRC),
      .EN_RST  (EN_RST),
      .MODE_RST(MODE_RST)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_lvl (sync_lvl),
      .src_rise(rise_v),
      .wr_en   (bus_we && (bank_sel == 1'(b))),
      .sel     (reg_sel),
      .wr_val  (bus_wdata[NUM_SRC-1:0]),
      .rd_val  (rd_b[b]),
      .raw_stat(raw_b[b]),
      .en_q    (en_b[b]),
      .mode_q  (mode_b[b]),
      .irq_q   (irq_b[b])
    );
  end

  assign bus_rdata = DATA_W'(rd_b[bank_sel]);
  assign irq_o     = irq_b[0];
  assign irq_sec_o = irq_b[1];
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NUM_SRC   = 22,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_BANKS = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [3:0]                        bus_addr,
  input logic                              bus_we,
  input logic [DATA_W-1:0]                 bus_wdata,
  input logic [DATA_W-1:0]                 bus_rdata,
  input logic                              irq_o,
  input logic                              irq_sec_o,
  input logic [NUM_SRC-1:0]                rise_v,
  input logic [NUM_BANKS-1:0][NUM_SRC-1:0] raw_b,
  input logic [NUM_BANKS-1:0][NUM_SRC-1:0] en_b,
  input logic [NUM_BANKS-1:0][NUM_SRC-1:0] mode_b
);
  // R1
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_SRC] == '0);

  // R3: a rising edge in latched mode sets the bit
  p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((rise_v & mode_b[0]) != '0) && !bus_we) |=>
      ((raw_b[0] & $past(rise_v & mode_b[0])) == $past(rise_v & mode_b[0])));

  // R3: latched bits hold while no write happens
  p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((mode_b[0] & raw_b[0]) != '0) && !bus_we) |=>
      ((raw_b[0] & $past(mode_b[0] & raw_b[0])) == $past(mode_b[0] & raw_b[0])));

  // R5
  p_ack_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:0] == 3'd2) |-> (bus_rdata == '0));

  // R6: an edge racing an ack of the same bit keeps the bit
  p_edge_beats_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd2 &&
     ((rise_v & mode_b[0] & bus_wdata[NUM_SRC-1:0]) != '0)) |=>
      ((raw_b[0] & $past(rise_v & mode_b[0])) == $past(rise_v & mode_b[0])));

  // R9
  p_masked_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:0] == 3'd5) |->
      (bus_rdata[NUM_SRC-1:0] == (raw_b[bus_addr[3]] & en_b[bus_addr[3]])));

  // R10
  p_hole_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:1] == 2'b11) |-> (bus_rdata == '0));

  // R12
  p_irq_main_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(raw_b[0] & en_b[0])));

  // R11
  p_irq_sec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sec_o == $past(|(raw_b[1] & en_b[1])));
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NUM_SRC  (NUM_SRC),
  .DATA_W   (DATA_W),
  .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .irq_sec_o(irq_sec_o),
  .rise_v   (rise_v),
  .raw_b    (raw_b),
  .en_b     (en_b),
  .mode_b   (mode_b)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [21:0] src_in = '0;
  logic        irq_o, irq_sec_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_o(irq_o), .irq_sec_o(irq_sec_o)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  waddr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h1, 32'h0, 32'h0000_3011, 4'd4},   // R4 enable reset
    '{1'b0, 4'h3, 32'h0, 32'h0000_0019, 4'd7},   // R7 mode reset
    '{1'b0, 4'h4, 32'h0, 32'h0000_0000, 4'd8},   // R8 spare reset
    '{1'b0, 4'h0, 32'h0, 32'h0000_0000, 4'd2},   // R2 raw idle
    '{1'b0, 4'h5, 32'h0, 32'h0000_0000, 4'd9},   // R9 masked idle
    '{1'b0, 4'h6, 32'h0, 32'h0000_0000, 4'd10},  // R10
    '{1'b0, 4'h7, 32'h0, 32'h0000_0000, 4'd10},  // R10
    '{1'b0, 4'h9, 32'h0, 32'h0000_3011, 4'd11},  // R11 second bank enable reset
    '{1'b0, 4'hB, 32'h0, 32'h0000_0019, 4'd11},  // R11 second bank mode reset
    '{1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0, 4'd1},
    '{1'b0, 4'h4, 32'h0, 32'h003F_FFFF, 4'd1},   // R1 upper bits dropped
    '{1'b0, 4'hC, 32'h0, 32'h0000_0000, 4'd11},  // R11 separate spare
    '{1'b1, 4'h9, 32'h0000_0005, 32'h0, 4'd11},
    '{1'b0, 4'h9, 32'h0, 32'h0000_0005, 4'd11},  // R11
    '{1'b0, 4'h1, 32'h0, 32'h0000_3011, 4'd11},  // R11 main enable untouched
    '{1'b1, 4'h2, 32'hFFFF_FFFF, 32'h0, 4'd5},
    '{1'b0, 4'h2, 32'h0, 32'h0000_0000, 4'd5},   // R5 ack reads zero
    '{1'b1, 4'h6, 32'hFFFF_FFFF, 32'h0, 4'd10},
    '{1'b0, 4'h6, 32'h0, 32'h0000_0000, 4'd10},  // R10 hole write ignored
    '{1'b1, 4'hC, 32'hA5A5_A5A5, 32'h0, 4'd1},
    '{1'b0, 4'hC, 32'h0, 32'h0025_A5A5, 4'd1},   // R1
    '{1'b0, 4'h4, 32'h0, 32'h003F_FFFF, 4'd11}   // R11 main spare kept
  };

  task automatic check(input logic [31:0] act, input logic [31:0] expv,
                       input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // called just after a falling edge; read is combinational
  task automatic rd(input logic [3:0] a, input logic [31:0] expv,
                    input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata, expv, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    wait_n(3);
    check({31'b0, irq_o}, 32'h0, "R12 irq_o in reset");
    rst_n = 1'b1;
    wait_n(2);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].waddr, VEC[i].data);
      else rd(VEC[i].waddr, VEC[i].expv, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end
    // now: main enable 3011, second bank enable 5, both modes 19

    // R2 / R12: level source 12
    @(negedge clk); src_in[12] = 1'b1;            // N0
    @(negedge clk);                               // after edge A
    rd(4'h0, 32'h0, "R2 level not yet through sync");
    @(negedge clk);                               // after edge B
    rd(4'h0, 32'h0000_1000, "R2 level visible after two edges");
    check({31'b0, irq_o}, 32'h0, "R12 irq_o one edge behind");
    @(negedge clk);                               // after edge C
    check({31'b0, irq_o}, 32'h1, "R12 irq_o asserted");
    check({31'b0, irq_sec_o}, 32'h0, "R11 sec not enabled for bit 12");
    rd(4'h8, 32'h0000_1000, "R11 second bank raw level");
    src_in[12] = 1'b0;
    wait_n(4);
    rd(4'h0, 32'h0, "R2 level falls");
    check({31'b0, irq_o}, 32'h0, "R12 irq_o released");

    // R3: pulse on latched source 0
    src_in[0] = 1'b1;
    wait_n(3);
    src_in[0] = 1'b0;
    wait_n(5);
    rd(4'h0, 32'h0000_0001, "R3 latched bit sticky");
    rd(4'h5, 32'h0000_0001, "R9 masked main");
    rd(4'hD, 32'h0000_0001, "R9 masked second bank");
    check({30'b0, irq_o, irq_sec_o}, 32'h3, "R12 both requests from latched bit");

    // R5 / R11: ack main only
    wr(4'h2, 32'h0000_0001);
    rd(4'h0, 32'h0, "R5 ack clears latched bit");
    rd(4'h8, 32'h0000_0001, "R11 second bank latch kept");
    @(negedge clk);
    check({30'b0, irq_o, irq_sec_o}, 32'h1, "R11 only secondary remains");
    wr(4'hA, 32'h0000_0001);
    @(negedge clk);
    check({31'b0, irq_sec_o}, 32'h0, "R11 secondary cleared by own ack");

    // R5: ack has no effect on level-mode bit
    src_in[12] = 1'b1;
    wait_n(3);
    wr(4'h2, 32'h0000_1000);
    rd(4'h0, 32'h0000_1000, "R5 ack ignored in level mode");
    src_in[12] = 1'b0;
    wait_n(3);

    // R6: edge and ack of bit 3 in the same cycle
    @(negedge clk); src_in[3] = 1'b1;             // N0
    @(negedge clk);                               // after edge A
    wr(4'h2, 32'h0000_0008);                      // captured at edge C
    rd(4'h0, 32'h0000_0008, "R6 edge wins over same-cycle ack");
    wr(4'h2, 32'h0000_0008);
    rd(4'h0, 32'h0, "R6 later ack clears");
    src_in[3] = 1'b0;
    wait_n(3);

    // R7: mode bit 0 back to level
    src_in[4] = 1'b1;
    wait_n(4);
    src_in[4] = 1'b0;
    wait_n(4);
    rd(4'h0, 32'h0000_0010, "R7 latched mode holds bit 4");
    wr(4'h3, 32'h0000_0000);
    rd(4'h0, 32'h0, "R7 level mode follows input");

    // reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h1, 32'h0000_3011, "R4 enable after reset");
    rd(4'h3, 32'h0000_0019, "R7 mode after reset");
    rd(4'h4, 32'h0, "R8 spare after reset");
    rd(4'h9, 32'h0000_3011, "R11 second bank after reset");
    check({30'b0, irq_o, irq_sec_o}, 32'h0, "R12 requests after reset");

    summary();
  end
endmodule